// File: doc/BRIEF.md
# External Bus Yield Controller

This block sits beside the local bus master of a processor and decides when the external memory bus is handed to an outside requester. The outside device signals its request on an active-low asynchronous input. The controller synchronizes that input and waits for a safe point. A safe point means no bus cycle is running, no atomic multi-cycle sequence or software lock holds the bus, and any open SDRAM banks have been closed with a precharge-all. At that point the controller floats the bus and acknowledges.

Release runs in a fixed order. The control strobes are first parked at their inactive levels for one cycle. The address, data and strobe pads are then floated on a rising clock edge. The active-low acknowledge follows on the next falling edge. When the request is withdrawn, the order reverses: the acknowledge is dropped first, then the pads are driven again with the strobes still inactive, and the local master regains its grant one cycle later.

Top module: `ext_bus_yield`

## Requirements
- R1: While reset is high and after it is released with no request, local_grant is 1 and bus_float, strobe_idle, pall_req are 0 and ack_n is 1.
- R2: The request passes a two-stage synchronizer. With nothing blocking, strobe_idle rises on the third rising edge after ext_req_n falls, and bus_float rises on the fourth.
- R3: ack_n goes low on the falling edge that follows the rising edge where bus_float rose. It is low only while bus_float is 1.
- R4: While cyc_busy is 1 the bus is not released. Release starts on the first rising edge where cyc_busy is seen at 0.
- R5: Any set bit of lock_vec blocks release. The bits are: bit 0 cache line fill, bit 1 cache write-back, bit 2 test-and-set read-to-write gap, bit 3 split access narrower than the access size, bit 4 16-byte DMA transfer, bit 5 display-controller burst.
- R6: sw_lock at 1 blocks release.
- R7: When dma_burst is 1, release is blocked if dma_yield_en is 0 and allowed if dma_yield_en is 1.
- R8: If bank_open is 1 when release becomes possible, pall_req is raised and held until pall_done is seen at 1. The bus floats only after that.
- R9: If the request is withdrawn while a precharge is pending, completion of the precharge returns the bus to the local master without floating it or acknowledging.
- R10: On withdrawal, ack_n rises on the falling edge after the third rising edge following ext_req_n rising. On the next rising edge bus_float drops while strobe_idle stays 1 and local_grant is 0. One edge later local_grant returns and strobe_idle clears.
- R11: ack_n is never low while cyc_busy, sw_lock, any lock_vec bit or pall_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_n | input | 1 | Asynchronous external bus request, active low |
| cyc_busy | input | 1 | A local bus cycle is in progress |
| lock_vec | input | NUM_LOCK | Atomic-sequence locks (see R5) |
| sw_lock | input | 1 | Software lock bit |
| dma_burst | input | 1 | DMA burst transfer in progress |
| dma_yield_en | input | 1 | Allow release during a DMA burst |
| bank_open | input | 1 | At least one SDRAM bank is active |
| pall_done | input | 1 | Precharge-all command completed |
| pall_req | output | 1 | Request a precharge-all command |
| local_grant | output | 1 | Local master may start new bus cycles |
| strobe_idle | output | 1 | Force control strobes to inactive levels |
| bus_float | output | 1 | Tri-state address, data and control pads |
| ext_ack_n | output | 1 | Bus acknowledge to requester, active low |

## Verification
The safety assertions assume that the local side cannot start work once it has lost the bus. cyc_busy, sw_lock and every lock_vec bit must therefore stay low while the bus is floated, and pall_done is only pulsed while pall_req is high. Every directed scenario follows this: it lifts any lock or busy condition before expecting release and keeps them low until local_grant is back. The bank status and precharge handshake are driven as a well-behaved controller would drive them.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  // Release sequencing states
  typedef enum logic [2:0] {
    ST_OWN     = 3'd0,  // local master owns the bus
    ST_PRECHG  = 3'd1,  // waiting for precharge-all to finish
    ST_QUIET   = 3'd2,  // strobes parked inactive, pads still driven
    ST_FLOAT   = 3'd3,  // pads floated, acknowledge active
    ST_UNACK   = 3'd4,  // acknowledge dropped, pads still floated
    ST_REDRIVE = 3'd5   // pads driven again with inactive strobes
  } yield_state_e;
endpackage

// File: rtl/ebr_req_sync.sv
module ebr_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n_async,
  output logic req_seen
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= req_n_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], req_n_async};
      end
    end
  endgenerate

  assign req_seen = ~chain[STAGES-1];
endmodule

// File: rtl/ebr_fsm.sv
module ebr_fsm
  import ebr_pkg::*;
#(
  parameter int NUM_LOCK = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_seen,
  input  logic                cyc_busy,
  input  logic [NUM_LOCK-1:0] lock_vec,
  input  logic                sw_lock,
  input  logic                dma_burst,
  input  logic                dma_yield_en,
  input  logic                bank_open,
  input  logic                pall_done,
  output yield_state_e        state_q,
  output yield_state_e        state_d
);
  logic blocked;
  logic boundary;

  // Any atomic sequence, the software lock, or a DMA burst without permission
  assign blocked  = (|lock_vec) | sw_lock | (dma_burst & ~dma_yield_en);
  assign boundary = req_seen & ~cyc_busy & ~blocked;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWN: begin
        if (boundary) state_d = bank_open ? ST_PRECHG : ST_QUIET;
      end
      ST_PRECHG: begin
        if (pall_done) state_d = req_seen ? ST_QUIET : ST_OWN;
      end
      ST_QUIET: begin
        state_d = req_seen ? ST_FLOAT : ST_OWN;
      end
      ST_FLOAT: begin
        if (!req_seen) state_d = ST_UNACK;
      end
      ST_UNACK:   state_d = ST_REDRIVE;
      ST_REDRIVE: state_d = ST_OWN;
      default:    state_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OWN;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/ebr_pad_ctl.sv
module ebr_pad_ctl
  import ebr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  yield_state_e state_q,
  input  yield_state_e state_d,
  output logic         local_grant,
  output logic         pall_req,
  output logic         strobe_idle,
  output logic         bus_float,
  output logic         ack_n
);
  // Rising-edge registered controls, decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      local_grant <= 1'b1;
      pall_req    <= 1'b0;
      strobe_idle <= 1'b0;
      bus_float   <= 1'b0;
    end else begin
      local_grant <= (state_d == ST_OWN);
      pall_req    <= (state_d == ST_PRECHG);
      strobe_idle <= (state_d inside {ST_QUIET, ST_FLOAT, ST_UNACK, ST_REDRIVE});
      bus_float   <= (state_d inside {ST_FLOAT, ST_UNACK});
    end
  end

  // Acknowledge moves half a cycle after the pads, on the falling edge
  always_ff @(negedge clk) begin
    if (rst) ack_n <= 1'b1;
    else     ack_n <= (state_q != ST_FLOAT);
  end
endmodule

// File: rtl/ext_bus_yield.sv
module ext_bus_yield #(
  parameter int NUM_LOCK    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ext_req_n,
  input  logic                cyc_busy,
  input  logic [NUM_LOCK-1:0] lock_vec,
  input  logic                sw_lock,
  input  logic                dma_burst,
  input  logic                dma_yield_en,
  input  logic                bank_open,
  input  logic                pall_done,
  output logic                pall_req,
  output logic                local_grant,
  output logic                strobe_idle,
  output logic                bus_float,
  output logic                ext_ack_n
);
  import ebr_pkg::*;

  logic         req_seen;
  yield_state_e st_q;
  yield_state_e st_d;

  ebr_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .req_n_async(ext_req_n),
    .req_seen   (req_seen)
  );

  ebr_fsm #(.NUM_LOCK(NUM_LOCK)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_seen    (req_seen),
    .cyc_busy    (cyc_busy),
    .lock_vec    (lock_vec),
    .sw_lock     (sw_lock),
    .dma_burst   (dma_burst),
    .dma_yield_en(dma_yield_en),
    .bank_open   (bank_open),
    .pall_done   (pall_done),
    .state_q     (st_q),
    .state_d     (st_d)
  );

  ebr_pad_ctl u_pad (
    .clk        (clk),
    .rst        (rst),
    .state_q    (st_q),
    .state_d    (st_d),
    .local_grant(local_grant),
    .pall_req   (pall_req),
    .strobe_idle(strobe_idle),
    .bus_float  (bus_float),
    .ack_n      (ext_ack_n)
  );
endmodule

// File: rtl/ebr_checker.sv
module ebr_checker #(
  parameter int NUM_LOCK = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                cyc_busy,
  input logic [NUM_LOCK-1:0] lock_vec,
  input logic                sw_lock,
  input logic                pall_done,
  input logic                pall_req,
  input logic                local_grant,
  input logic                strobe_idle,
  input logic                bus_float,
  input logic                ext_ack_n
);
  assert_ack_floated_R3: assert property (@(posedge clk) disable iff (rst)
    !ext_ack_n |-> bus_float);

  assert_ack_safe_R11: assert property (@(posedge clk) disable iff (rst)
    !ext_ack_n |-> (!cyc_busy && !sw_lock && (lock_vec == '0) && !pall_req));

  // Covers R4 and R6 as well: busy or locked keeps the grant
  assert_hold_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (local_grant && (cyc_busy || sw_lock || (|lock_vec))) |=> local_grant);

  assert_pall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pall_req && !pall_done) |=> pall_req);

  assert_quiet_first_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_float) |-> $past(strobe_idle));

  assert_redrive_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_float) |-> (strobe_idle && !local_grant && ext_ack_n));
endmodule

bind ext_bus_yield ebr_checker #(.NUM_LOCK(NUM_LOCK)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cyc_busy   (cyc_busy),
  .lock_vec   (lock_vec),
  .sw_lock    (sw_lock),
  .pall_done  (pall_done),
  .pall_req   (pall_req),
  .local_grant(local_grant),
  .strobe_idle(strobe_idle),
  .bus_float  (bus_float),
  .ext_ack_n  (ext_ack_n)
);

// File: tb/test_ext_bus_yield.sv
`timescale 1ns/1ps
module test_ext_bus_yield;
  localparam int NL = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ext_req_n = 1'b1;
  logic          cyc_busy = 1'b0;
  logic [NL-1:0] lock_vec = '0;
  logic          sw_lock = 1'b0;
  logic          dma_burst = 1'b0;
  logic          dma_yield_en = 1'b0;
  logic          bank_open = 1'b0;
  logic          pall_done = 1'b0;
  logic          pall_req, local_grant, strobe_idle, bus_float, ext_ack_n;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  ext_bus_yield #(.NUM_LOCK(NL)) i_ext_bus_yield (
    .clk(clk), .rst(rst), .ext_req_n(ext_req_n), .cyc_busy(cyc_busy),
    .lock_vec(lock_vec), .sw_lock(sw_lock), .dma_burst(dma_burst),
    .dma_yield_en(dma_yield_en), .bank_open(bank_open), .pall_done(pall_done),
    .pall_req(pall_req), .local_grant(local_grant), .strobe_idle(strobe_idle),
    .bus_float(bus_float), .ext_ack_n(ext_ack_n)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Request already seen and nothing blocks: next rising edge leaves ownership
  task automatic go_float(input string req);
    tick(1);
    chk(req, "strobe_idle before float", strobe_idle, 1'b1);
    chk(req, "bus_float before float", bus_float, 1'b0);
    tick(1);
    chk(req, "bus_float raised", bus_float, 1'b1);
    chk(req, "ack_n still high at rising edge", ext_ack_n, 1'b1);
    #4;
    chk("R3", "ack_n low after falling edge", ext_ack_n, 1'b0);
  endtask

  task automatic give_back(input string req);
    ext_req_n = 1'b1;
    tick(2);
    chk(req, "still floated", bus_float, 1'b1);
    chk(req, "still acknowledged", ext_ack_n, 1'b0);
    tick(1);
    chk(req, "float held during unack", bus_float, 1'b1);
    #4;
    chk(req, "ack_n released", ext_ack_n, 1'b1);
    tick(1);
    chk(req, "pads driven again", bus_float, 1'b0);
    chk(req, "strobes still idle", strobe_idle, 1'b1);
    chk(req, "grant still withheld", local_grant, 1'b0);
    tick(1);
    chk(req, "grant returned", local_grant, 1'b1);
    chk(req, "strobes released", strobe_idle, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    chk("R1", "grant in reset", local_grant, 1'b1);
    chk("R1", "float in reset", bus_float, 1'b0);
    chk("R1", "ack in reset", ext_ack_n, 1'b1);
    rst = 1'b0;
    tick(2);
    chk("R1", "pall_req after reset", pall_req, 1'b0);
    chk("R1", "strobe_idle after reset", strobe_idle, 1'b0);
    chk("R1", "grant after reset", local_grant, 1'b1);
  endtask

  task automatic t_basic();
    ext_req_n = 1'b0;
    tick(2);
    chk("R2", "no action during sync", strobe_idle, 1'b0);
    chk("R2", "grant during sync", local_grant, 1'b1);
    go_float("R2");
    give_back("R10");
  endtask

  task automatic t_busy();
    cyc_busy = 1'b1;
    ext_req_n = 1'b0;
    tick(6);
    chk("R4", "no release while busy", bus_float, 1'b0);
    chk("R4", "grant kept while busy", local_grant, 1'b1);
    cyc_busy = 1'b0;
    go_float("R4");
    give_back("R4");
  endtask

  task automatic t_locks();
    for (int b = 0; b < NL; b++) begin
      lock_vec = NL'(1) << b;
      ext_req_n = 1'b0;
      tick(5);
      chk("R5", $sformatf("lock bit %0d blocks", b), strobe_idle, 1'b0);
      chk("R5", $sformatf("lock bit %0d keeps grant", b), local_grant, 1'b1);
      lock_vec = '0;
      go_float("R5");
      give_back("R5");
    end
  endtask

  task automatic t_swlock();
    sw_lock = 1'b1;
    ext_req_n = 1'b0;
    tick(5);
    chk("R6", "sw lock blocks", bus_float, 1'b0);
    chk("R6", "sw lock keeps strobes", strobe_idle, 1'b0);
    sw_lock = 1'b0;
    go_float("R6");
    give_back("R6");
  endtask

  task automatic t_dma();
    dma_burst = 1'b1;
    dma_yield_en = 1'b0;
    ext_req_n = 1'b0;
    tick(5);
    chk("R7", "burst blocks without permission", strobe_idle, 1'b0);
    dma_yield_en = 1'b1;
    go_float("R7");
    give_back("R7");
    dma_burst = 1'b0;
    dma_yield_en = 1'b0;
  endtask

  task automatic t_pall();
    bank_open = 1'b1;
    ext_req_n = 1'b0;
    tick(3);
    chk("R8", "precharge requested", pall_req, 1'b1);
    chk("R8", "grant withdrawn", local_grant, 1'b0);
    tick(3);
    chk("R8", "precharge held", pall_req, 1'b1);
    chk("R8", "no float before precharge done", bus_float, 1'b0);
    chk("R11", "no ack while precharge pending", ext_ack_n, 1'b1);
    pall_done = 1'b1;
    tick(1);
    chk("R8", "precharge request cleared", pall_req, 1'b0);
    chk("R8", "strobes parked", strobe_idle, 1'b1);
    pall_done = 1'b0;
    bank_open = 1'b0;
    tick(1);
    chk("R8", "float after precharge", bus_float, 1'b1);
    #4;
    chk("R8", "ack after precharge", ext_ack_n, 1'b0);
    give_back("R10");
  endtask

  task automatic t_withdraw();
    bank_open = 1'b1;
    ext_req_n = 1'b0;
    tick(3);
    chk("R9", "precharge requested", pall_req, 1'b1);
    ext_req_n = 1'b1;
    tick(2);
    pall_done = 1'b1;
    tick(1);
    chk("R9", "grant back", local_grant, 1'b1);
    chk("R9", "precharge cleared", pall_req, 1'b0);
    chk("R9", "never floated", bus_float, 1'b0);
    pall_done = 1'b0;
    bank_open = 1'b0;
    #4;
    chk("R9", "never acknowledged", ext_ack_n, 1'b1);
    tick(3);
    chk("R9", "stays owned", bus_float, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_busy();
        t_locks();
        t_swlock();
        t_dma();
        t_pall();
        t_withdraw();
      end
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule